// File: doc/BRIEF.md
# Multi-Pattern Bit-Error-Rate Test Transmit Generator

This block produces a serial test bit stream, one bit per clock-enable cycle, for a bit-error-rate test of a transmit path. The pattern comes from one of four families: a 2^15-1 pseudorandom sequence, a 2^20-1 quasi-random signal source with zero suppression, a repeating word of 1 to 32 bits, and a pair of 16-bit words sent alternately that swap after a programmed number of words. A host can request a single bit error, which inverts exactly one emitted bit.

All settings are plain input ports that stay static while the stream runs. A restart strobe returns the selected pattern to its initial state. A route select steers the registered stream to one of the low-speed tributary outputs or to the high-rate framer output. Every other routed output stays at zero.

Top module: `bert_tx_gen`

## Requirements
- R1: While `rstN` is low, `txBit`, every bit of `tribData` and `framerData` are 0, and no error request is pending.
- R2: `txBit` is registered. It changes only at the clock edge of a cycle where `bitEnable` is 1 and `restartPattern` is 0. In that cycle exactly one pattern bit is emitted and the pattern state advances. In all other cycles `txBit` holds.
- R3: A cycle with `restartPattern` high takes priority over `bitEnable`. It emits nothing and reloads the pattern: both LFSRs are loaded from the seed, the repeat index goes to bit `patLenM1`, and the alternating logic goes to word A, bit 15, with its word count at zero. The zero-run count is also cleared.
- R4: `modeSel` encoding: 0 = 2^15-1 pseudorandom, 1 = quasi-random, 2 = repeating word, 3 = alternating words.
- R5: Mode 0 uses a 15-bit Fibonacci LFSR `s`. The emitted bit is `s[14]`, and the next state is `{s[13:0], s[14]^s[13]}`. It is seeded from `lfsrSeed[14:0]`; a zero seed becomes all ones.
- R6: Mode 1 uses a 20-bit LFSR `q`. The raw bit is `q[19]`, and the next state is `{q[18:0], q[19]^q[16]}`. It is seeded from `lfsrSeed[19:0]`; a zero seed becomes all ones.
- R7: In mode 1, when the previous 14 emitted quasi-random bits (before error inversion) were all 0, the emitted bit is forced to 1.
- R8: Mode 2 emits `patWord` bits `patLenM1` down to 0, most significant first, then repeats. The length is `patLenM1`+1, from 1 to 32.
- R9: Mode 3 emits `altWordA` and then `altWordB`, each most significant bit first. The word in use swaps after every `altRepeatM1`+1 complete 16-bit words, so the swap interval runs from 1 to 256 words.
- R10: A one-cycle `errInsert` pulse inverts exactly the next emitted bit. A pulse in an emitting cycle applies to that cycle's bit. Several pulses before one emission give one inversion.
- R11: `routeSel` encoding: 0 drives nothing, k in 1..28 drives `tribData[k-1]` with `txBit`, and 29 drives `framerData` with `txBit`. All unselected outputs are 0, and codes 30 and 31 drive nothing. Routing follows `routeSel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitEnable | input | 1 | Emit one bit this cycle |
| restartPattern | input | 1 | Reload the pattern to its initial state |
| modeSel | input | 2 | Pattern family |
| lfsrSeed | input | 20 | LFSR seed (low 15 bits for mode 0) |
| patWord | input | 32 | Repeating word |
| patLenM1 | input | 5 | Repeat length minus one |
| altWordA | input | 16 | First alternating word |
| altWordB | input | 16 | Second alternating word |
| altRepeatM1 | input | 8 | Words per swap minus one |
| errInsert | input | 1 | Single-bit error request |
| routeSel | input | 5 | Output route |
| txBit | output | 1 | Generated bit |
| tribData | output | 28 | Tributary outputs |
| framerData | output | 1 | Framer-path output |

## Verification
The bench runs the quasi-random mode long enough to pass through LFSR stretches holding 14 or more zeros. A design that counts the run wrongly, or that counts the inverted bits, forces a 1 at the wrong place or never. It exercises repeat lengths of 1 and 32 and swap intervals of 1 and 256 words, where an off-by-one in the index or the word count shifts the stream by one bit or one word. It also issues restarts in the same cycle as enable and error pulses, and error pulses during enable gaps. Taking the wrong priority there either loses the inversion or applies it twice.

// File: rtl/bert_tx_pkg.sv
package bert_tx_pkg;

  typedef enum logic [1:0] {
    MODE_PRBS15 = 2'd0,
    MODE_QRSS   = 2'd1,
    MODE_REPEAT = 2'd2,
    MODE_ALT    = 2'd3
  } bertMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      restart;
    logic      advance;
    logic      flip;
    bertMode_e mode;
  } genCtrl_t;

endpackage

// File: rtl/bert_lfsr.sv
module bert_lfsr #(
  parameter int W   = 15,
  parameter int TAP = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic         msb
);
  logic [W-1:0] stateQ;
  logic [W-1:0] initVal;
  logic         feedback;

  assign initVal  = (|seed) ? seed : {W{1'b1}};
  assign feedback = stateQ[W-1] ^ stateQ[TAP-1];
  assign msb      = stateQ[W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= {W{1'b1}};
    end else if (restart) begin
      stateQ <= initVal;
    end else if (step) begin
      stateQ <= {stateQ[W-2:0], feedback};
    end
  end
endmodule

// File: rtl/bert_tx_ctrl.sv
module bert_tx_ctrl
  import bert_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEnable,
  input  logic       restartPattern,
  input  logic       errInsert,
  input  logic [1:0] modeSel,
  output genCtrl_t   ctrl,
  output logic       errPending
);
  logic errFlagQ;
  logic errNow;
  logic advance;

  assign advance    = bitEnable & ~restartPattern;
  assign errNow     = errFlagQ | errInsert;
  assign errPending = errFlagQ;

  always_comb begin
    ctrl.restart = restartPattern;
    ctrl.advance = advance;
    ctrl.flip    = advance & errNow;
    ctrl.mode    = bertMode_e'(modeSel);
  end

  // A request waits until a bit is emitted, then it is spent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlagQ <= 1'b0;
    end else if (advance) begin
      errFlagQ <= 1'b0;
    end else begin
      errFlagQ <= errNow;
    end
  end
endmodule

// File: rtl/bert_tx_datapath.sv
module bert_tx_datapath
  import bert_tx_pkg::*;
#(
  parameter int PAT_W      = 32,
  parameter int ALT_W      = 16,
  parameter int ALT_CNT_W  = 8,
  parameter int PRBS_W     = 15,
  parameter int PRBS_TAP   = 14,
  parameter int QRSS_W     = 20,
  parameter int QRSS_TAP   = 17,
  parameter int ZERO_LIMIT = 14,
  localparam int LEN_W     = $clog2(PAT_W),
  localparam int POS_W     = $clog2(ALT_W),
  localparam int ZR_W      = $clog2(ZERO_LIMIT + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  genCtrl_t             ctrl,
  input  logic [QRSS_W-1:0]    lfsrSeed,
  input  logic [PAT_W-1:0]     patWord,
  input  logic [LEN_W-1:0]     patLenM1,
  input  logic [ALT_W-1:0]     altWordA,
  input  logic [ALT_W-1:0]     altWordB,
  input  logic [ALT_CNT_W-1:0] altRepeatM1,
  output logic                 txBit
);
  logic prbsMsb;
  logic qrssMsb;
  logic prbsStep;
  logic qrssStep;
  logic genBit;
  logic forceOne;

  logic [LEN_W-1:0]     repIdxQ;
  logic [POS_W-1:0]     altPosQ;
  logic [ALT_CNT_W-1:0] altWordsQ;
  logic                 altSelQ;
  logic [ZR_W-1:0]      zeroRunQ;
  logic                 outQ;

  assign prbsStep = ctrl.advance && (ctrl.mode == MODE_PRBS15);
  assign qrssStep = ctrl.advance && (ctrl.mode == MODE_QRSS);

  bert_lfsr #(.W(PRBS_W), .TAP(PRBS_TAP)) uPrbs (
    .clk     (clk),
    .rstN    (rstN),
    .restart (ctrl.restart),
    .step    (prbsStep),
    .seed    (lfsrSeed[PRBS_W-1:0]),
    .msb     (prbsMsb)
  );

  bert_lfsr #(.W(QRSS_W), .TAP(QRSS_TAP)) uQrss (
    .clk     (clk),
    .rstN    (rstN),
    .restart (ctrl.restart),
    .step    (qrssStep),
    .seed    (lfsrSeed),
    .msb     (qrssMsb)
  );

  assign forceOne = (zeroRunQ == ZR_W'(ZERO_LIMIT));

  always_comb begin
    unique case (ctrl.mode)
      MODE_PRBS15: genBit = prbsMsb;
      MODE_QRSS:   genBit = forceOne | qrssMsb;
      MODE_REPEAT: genBit = patWord[repIdxQ];
      default:     genBit = altSelQ ? altWordB[altPosQ] : altWordA[altPosQ];
    endcase
  end

  // Output register and zero-run tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ     <= 1'b0;
      zeroRunQ <= '0;
    end else if (ctrl.restart) begin
      zeroRunQ <= '0;
    end else if (ctrl.advance) begin
      outQ <= genBit ^ ctrl.flip;
      if (qrssStep) begin
        zeroRunQ <= genBit ? '0 : zeroRunQ + 1'b1;
      end
    end
  end

  // Repeating-word index, counts down and wraps to the programmed top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repIdxQ <= '1;
    end else if (ctrl.restart) begin
      repIdxQ <= patLenM1;
    end else if (ctrl.advance && (ctrl.mode == MODE_REPEAT)) begin
      repIdxQ <= (repIdxQ == '0) ? patLenM1 : repIdxQ - 1'b1;
    end
  end

  // Alternating-word position, word count and word select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altPosQ   <= '1;
      altWordsQ <= '0;
      altSelQ   <= 1'b0;
    end else if (ctrl.restart) begin
      altPosQ   <= '1;
      altWordsQ <= '0;
      altSelQ   <= 1'b0;
    end else if (ctrl.advance && (ctrl.mode == MODE_ALT)) begin
      altPosQ <= altPosQ - 1'b1;
      if (altPosQ == '0) begin
        if (altWordsQ == altRepeatM1) begin
          altWordsQ <= '0;
          altSelQ   <= ~altSelQ;
        end else begin
          altWordsQ <= altWordsQ + 1'b1;
        end
      end
    end
  end

  assign txBit = outQ;
endmodule

// File: rtl/bert_tx_gen.sv
module bert_tx_gen
  import bert_tx_pkg::*;
#(
  parameter int NUM_TRIB  = 28,
  parameter int ROUTE_W   = 5,
  parameter int PAT_W     = 32,
  parameter int ALT_W     = 16,
  parameter int ALT_CNT_W = 8,
  parameter int SEED_W    = 20,
  localparam int LEN_W    = $clog2(PAT_W),
  localparam int FRAMER_CODE = NUM_TRIB + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitEnable,
  input  logic                 restartPattern,
  input  logic [1:0]           modeSel,
  input  logic [SEED_W-1:0]    lfsrSeed,
  input  logic [PAT_W-1:0]     patWord,
  input  logic [LEN_W-1:0]     patLenM1,
  input  logic [ALT_W-1:0]     altWordA,
  input  logic [ALT_W-1:0]     altWordB,
  input  logic [ALT_CNT_W-1:0] altRepeatM1,
  input  logic                 errInsert,
  input  logic [ROUTE_W-1:0]   routeSel,
  output logic                 txBit,
  output logic [NUM_TRIB-1:0]  tribData,
  output logic                 framerData
);
  genCtrl_t ctrl;
  logic     errPending;

  bert_tx_ctrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .bitEnable      (bitEnable),
    .restartPattern (restartPattern),
    .errInsert      (errInsert),
    .modeSel        (modeSel),
    .ctrl           (ctrl),
    .errPending     (errPending)
  );

  bert_tx_datapath #(
    .PAT_W     (PAT_W),
    .ALT_W     (ALT_W),
    .ALT_CNT_W (ALT_CNT_W),
    .QRSS_W    (SEED_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .lfsrSeed    (lfsrSeed),
    .patWord     (patWord),
    .patLenM1    (patLenM1),
    .altWordA    (altWordA),
    .altWordB    (altWordB),
    .altRepeatM1 (altRepeatM1),
    .txBit       (txBit)
  );

  for (genvar k = 0; k < NUM_TRIB; k++) begin : gRoute
    assign tribData[k] = txBit & (routeSel == ROUTE_W'(k + 1));
  end

  assign framerData = txBit & (routeSel == ROUTE_W'(FRAMER_CODE));
endmodule

// File: rtl/bert_tx_gen_chk.sv
module bert_tx_gen_chk #(
  parameter int NUM_TRIB = 28,
  parameter int ROUTE_W  = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                bitEnable,
  input logic                restartPattern,
  input logic                errInsert,
  input logic [ROUTE_W-1:0]  routeSel,
  input logic                txBit,
  input logic [NUM_TRIB-1:0] tribData,
  input logic                framerData,
  input logic                errPending
);
  AST_RESET_STATE: assert property (@(posedge clk) $rose(rstN) |-> (!txBit && !errPending)); // R1

  AST_HOLD_NO_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(bitEnable && !restartPattern) |=> $stable(txBit)); // R2

  AST_ERR_SPENT: assert property (@(posedge clk) disable iff (!rstN)
    (bitEnable && !restartPattern) |=> !errPending); // R10

  AST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (errInsert && !(bitEnable && !restartPattern)) |=> errPending); // R10

  AST_NO_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (routeSel == '0) |-> (tribData == '0 && !framerData)); // R11

  AST_ROUTE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tribData, framerData})); // R11
endmodule

bind bert_tx_gen bert_tx_gen_chk #(.NUM_TRIB(NUM_TRIB), .ROUTE_W(ROUTE_W)) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .bitEnable      (bitEnable),
  .restartPattern (restartPattern),
  .errInsert      (errInsert),
  .routeSel       (routeSel),
  .txBit          (txBit),
  .tribData       (tribData),
  .framerData     (framerData),
  .errPending     (errPending)
);

// File: tb/tb_bert_tx_gen.sv
`timescale 1ns/1ps
module tb_bert_tx_gen;
  localparam int NUM_TRIB = 28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEnable = 1'b0;
  logic        restartPattern = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [19:0] lfsrSeed = '0;
  logic [31:0] patWord = '0;
  logic [4:0]  patLenM1 = '0;
  logic [15:0] altWordA = '0;
  logic [15:0] altWordB = '0;
  logic [7:0]  altRepeatM1 = '0;
  logic        errInsert = 1'b0;
  logic [4:0]  routeSel = '0;
  logic        txBit;
  logic [NUM_TRIB-1:0] tribData;
  logic        framerData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bert_tx_gen dut (
    .clk(clk), .rstN(rstN), .bitEnable(bitEnable), .restartPattern(restartPattern),
    .modeSel(modeSel), .lfsrSeed(lfsrSeed), .patWord(patWord), .patLenM1(patLenM1),
    .altWordA(altWordA), .altWordB(altWordB), .altRepeatM1(altRepeatM1),
    .errInsert(errInsert), .routeSel(routeSel), .txBit(txBit),
    .tribData(tribData), .framerData(framerData)
  );

  // Behavioural reference model
  int  mPrbs, mQrss, mRep, mPos, mWords, mSel, mZeros;
  bit  mErr, mOut, mFlipped;

  function automatic int seedOf(int s, int w);
    int v = s & ((1 << w) - 1);
    return (v == 0) ? ((1 << w) - 1) : v;
  endfunction

  always @(posedge clk) begin
    bit b;
    if (!rstN) begin
      mPrbs = 32'h7FFF; mQrss = 32'hFFFFF; mRep = 31; mPos = 15;
      mWords = 0; mSel = 0; mZeros = 0; mErr = 0; mOut = 0; mFlipped = 0;
    end else if (restartPattern) begin // R3: restart wins over enable
      mPrbs = seedOf(lfsrSeed, 15); mQrss = seedOf(lfsrSeed, 20);
      mRep = patLenM1; mPos = 15; mWords = 0; mSel = 0; mZeros = 0;
      mErr = mErr | errInsert;
    end else if (bitEnable) begin
      case (modeSel)
        2'd0: begin
          b = mPrbs[14];
          mPrbs = ((mPrbs << 1) | (mPrbs[14] ^ mPrbs[13])) & 32'h7FFF;
        end
        2'd1: begin
          b = (mZeros >= 14) ? 1'b1 : mQrss[19];
          mZeros = b ? 0 : mZeros + 1;
          mQrss = ((mQrss << 1) | (mQrss[19] ^ mQrss[16])) & 32'hFFFFF;
        end
        2'd2: begin
          b = patWord[mRep];
          mRep = (mRep == 0) ? int'(patLenM1) : mRep - 1;
        end
        default: begin
          b = mSel ? altWordB[mPos] : altWordA[mPos];
          if (mPos == 0) begin
            mPos = 15;
            if (mWords == int'(altRepeatM1)) begin mWords = 0; mSel = 1 - mSel; end
            else mWords = mWords + 1;
          end else mPos = mPos - 1;
        end
      endcase
      mFlipped = mErr | errInsert;
      mOut = b ^ mFlipped;
      mErr = 0;
    end else begin
      mErr = mErr | errInsert;
    end
  end

  function automatic string modeTag(logic [1:0] m, bit f);
    if (f) return "R10";
    case (m)
      2'd0: return "R4/R5";
      2'd1: return "R6,R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    logic [NUM_TRIB-1:0] expTrib;
    bit expFr;
    if (!done) begin
      expTrib = '0;
      if (routeSel >= 1 && routeSel <= NUM_TRIB) expTrib[routeSel-1] = mOut;
      expFr = (routeSel == 5'd29) ? mOut : 1'b0;
      if (!rstN) begin
        check("R1", {31'b0, txBit}, 32'd0);
        check("R1", {4'b0, tribData}, 32'd0);
        check("R1", {31'b0, framerData}, 32'd0);
      end else begin
        check(modeTag(modeSel, mFlipped), {31'b0, txBit}, {31'b0, mOut}); // R2 by gaps
        check("R11", {4'b0, tribData}, {4'b0, expTrib});
        check("R11", {31'b0, framerData}, {31'b0, expFr});
      end
    end
  end

  task automatic doRestart();
    @(posedge clk); #1;
    restartPattern = 1'b1; bitEnable = 1'b0; errInsert = 1'b0;
    @(posedge clk); #1;
    restartPattern = 1'b0;
  endtask

  // enPct: enable density, errPct: error pulses, ldPct: restart pulses (R3)
  task automatic runPhase(int cycles, int enPct, int errPct, int ldPct);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      bitEnable      = (($urandom % 100) < enPct);
      errInsert      = (($urandom % 100) < errPct);
      restartPattern = (($urandom % 1000) < ldPct);
    end
    @(posedge clk); #1;
    bitEnable = 1'b0; errInsert = 1'b0; restartPattern = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    routeSel = 5'd29;
    repeat (4) @(posedge clk);   // R1 checked during reset
    #1 rstN = 1'b1;

    // R5: nonzero seed, then zero seed with gaps and errors
    modeSel = 2'd0; lfsrSeed = 20'h01234; routeSel = 5'd5;
    doRestart(); runPhase(300, 100, 0, 0);
    lfsrSeed = 20'h00000; routeSel = 5'd29;
    doRestart(); runPhase(400, 70, 5, 0);

    // R6, R7: long quasi-random run crossing zero stretches
    modeSel = 2'd1; lfsrSeed = 20'h00001; routeSel = 5'd1;
    doRestart(); runPhase(40000, 100, 0, 0);
    lfsrSeed = 20'h0; routeSel = 5'd28;
    doRestart(); runPhase(3000, 80, 3, 2);

    // R8: lengths 1, 32 and 5
    modeSel = 2'd2; patWord = 32'hA5C3_0F96; patLenM1 = 5'd0; routeSel = 5'd0;
    doRestart(); runPhase(100, 100, 2, 0);
    patLenM1 = 5'd31; routeSel = 5'd30;
    doRestart(); runPhase(300, 100, 0, 0);
    patLenM1 = 5'd4; routeSel = 5'd12;
    doRestart(); runPhase(400, 60, 8, 10);

    // R9: swap every word, every 256 words, every 3 words
    modeSel = 2'd3; altWordA = 16'hF00D; altWordB = 16'h1234; altRepeatM1 = 8'd0;
    doRestart(); runPhase(200, 100, 0, 0);
    altRepeatM1 = 8'd255; routeSel = 5'd29;
    doRestart(); runPhase(9000, 100, 0, 0);
    altRepeatM1 = 8'd2; routeSel = 5'd3;
    doRestart(); runPhase(800, 60, 6, 5);

    // R10, R3: dense error and restart collisions
    modeSel = 2'd2; patLenM1 = 5'd7; patWord = 32'h0000_00FF;
    doRestart(); runPhase(1500, 50, 30, 40);

    // R11: sweep every route code
    modeSel = 2'd0; lfsrSeed = 20'h00ABC;
    doRestart();
    for (int r = 0; r < 32; r++) begin
      routeSel = 5'(r);
      runPhase(12, 100, 0, 0);
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule